// File: doc/BRIEF.md
# PWM Timer with Graceful Stop

This block is a free-running up-counter that produces a pulse-width modulated pin from three software-written values: a control word, a load value that fixes the period, and a match value that fixes the switching point inside the period. Software writes these values through a single-cycle write port. The block returns the live state of its run bit, so software can watch for the end of a run.

Each period, the counter climbs from just above the load value up to the all-ones value. When it reaches all-ones, an overflow occurs. If auto-reload is set, the counter then reloads and starts a new period. If auto-reload is clear, the counter halts and the hardware clears the run bit itself. This gives software a graceful stop: it clears auto-reload and leaves start set, and the current period runs to its end before the pin goes quiet. Writing start as 0 is an abrupt stop instead.

Load and match values are shadowed. A write made during a period takes effect from the next period.

Top module: `pwm_timer`

## Requirements
- R1: Write addresses are decoded as follows. Address 0 is the control word, address 1 the load value, address 2 the match value, and address 3 is ignored. Control bits: bit 0 is run/start, bit 1 is auto-reload, bit 2 is compare enable, bit 3 is polarity (1 means the pin idles high), and bit 4 is trigger mode (1 means overflow and compare, 0 means overflow only).
- R2: After reset, `run_o` is 0, `pwm_o` is 0 and all control bits are clear.
- R3: A control write with bit 0 set while stopped starts a period. Each period lasts 0xFFFFFFFF minus the load value in clock cycles. The counter passes through load+1 up to 0xFFFFFFFF, and the overflow happens in the cycle it holds 0xFFFFFFFF.
- R4: In overflow-and-compare mode with compare enabled, the pin is at its idle level at the start of each period. It turns active in the cycle after the counter equals the match value, and returns to idle at each overflow. It is therefore active for 0xFFFFFFFF minus the match value cycles per period.
- R5: With compare enabled cleared, the compare point has no effect, and in overflow-and-compare mode the pin stays at idle.
- R6: In overflow-only mode, the pin level inverts at every overflow that reloads, giving a square wave of twice the period.
- R7: `pwm_o` equals the internal level XOR the polarity bit. Whenever the timer is stopped, the pin sits at the polarity-defined idle level.
- R8: Clearing auto-reload while the run bit stays 1 lets the current period complete. At its overflow, `run_o` falls and the pin returns to idle without a reload.
- R9: A control write with bit 0 clear stops the timer in the next cycle, with the pin at idle.
- R10: Load and match writes made while running do not change the current period. They are applied at the next reload.
- R11: A control write with bit 0 set while already running updates the mode bits but does not restart the counter or the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| pwm_o | output | 1 | PWM pin |
| run_o | output | 1 | Live run (start) bit |

## Verification
The pin is tried in overflow-and-compare mode with two different load/match pairs. This shows whether the period length and the active width follow the values that were loaded, and whether a new pair waits for the reload. The same waveform is then run with compare disabled, in overflow-only mode, and with inverted polarity. These runs separate the compare path, the overflow toggle and the output XOR. Both stop styles are applied mid-period: the graceful stop must run to the overflow, while the abrupt stop must act in the next cycle. A write to the unused address and a control rewrite during a run confirm that neither one disturbs the running period.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_LOAD  = 2'd1,
    ADDR_MATCH = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_ARLD = 1;
  localparam int unsigned BIT_CMPE = 2;
  localparam int unsigned BIT_POL  = 3;
  localparam int unsigned BIT_TRIG = 4;

  typedef struct packed {
    logic trig_both;
    logic pol;
    logic cmp_en;
    logic auto_rld;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              ovf_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CNT_W-1:0]  match_o,
  output logic              start_o,
  output logic              halt_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q, match_q;
  logic             wr_ctrl, run_d, end_run;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign end_run = ovf_i && !ctrl_q.auto_rld;

  always_comb begin
    run_d = ctrl_q.run;
    if (wr_ctrl) run_d = ctrl_q.run ? (wr_data_i[BIT_RUN] && !end_run) : wr_data_i[BIT_RUN];
    else if (ctrl_q.run && end_run) run_d = 1'b0;
  end

  assign start_o = wr_ctrl && wr_data_i[BIT_RUN] && !ctrl_q.run;
  assign halt_o  = ctrl_q.run && !run_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
    end else begin
      ctrl_q.run <= run_d;
      if (wr_ctrl) begin
        ctrl_q.auto_rld  <= wr_data_i[BIT_ARLD];
        ctrl_q.cmp_en    <= wr_data_i[BIT_CMPE];
        ctrl_q.pol       <= wr_data_i[BIT_POL];
        ctrl_q.trig_both <= wr_data_i[BIT_TRIG];
      end
      if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_LOAD))  load_q  <= wr_data_i;
      if (wr_en_i && wr_addr_i == ADDR_W'(ADDR_MATCH)) match_q <= wr_data_i;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign load_o  = load_q;
  assign match_o = match_q;

  // R8: overflow without auto-reload ends the run
  a_r8_graceful_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run && ovf_i && !ctrl_q.auto_rld && !wr_en_i |=> !ctrl_q.run);
  // R9: writing start low stops at once
  a_r9_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl && !wr_data_i[BIT_RUN] |=> !ctrl_q.run);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             auto_rld_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] match_i,
  output logic             ovf_o,
  output logic             cmp_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, match_act_q;

  assign ovf_o = run_i && (cnt_q == CNT_MAX);
  assign cmp_o = run_i && (cnt_q == match_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      match_act_q <= '0;
    end else if (start_i) begin
      cnt_q       <= load_i + ONE;
      match_act_q <= match_i;
    end else if (run_i) begin
      if (ovf_o) begin
        // shadowed values enter only here
        if (auto_rld_i) begin
          cnt_q       <= load_i + ONE;
          match_act_q <= match_i;
        end
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  // R3: counter steps by one inside a period
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !ovf_o && !start_i |=> cnt_q == $past(cnt_q) + ONE);
  // R10: active match only changes at start or reload
  a_r10_match_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !ovf_o && !start_i |=> $stable(match_act_q));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic halt_i,
  input  logic run_i,
  input  logic ovf_i,
  input  logic cmp_i,
  input  logic cmp_en_i,
  input  logic trig_both_i,
  input  logic pol_i,
  output logic pwm_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 lvl_q <= 1'b0;
    else if (start_i || halt_i)                  lvl_q <= 1'b0;
    else if (run_i && ovf_i)                     lvl_q <= trig_both_i ? 1'b0 : !lvl_q;
    else if (run_i && cmp_i && cmp_en_i && trig_both_i) lvl_q <= !lvl_q;
  end

  assign pwm_o = lvl_q ^ pol_i;

  // R4: each reload in dual-trigger mode opens at idle
  a_r4_period_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && ovf_i && trig_both_i && !halt_i |=> !lvl_q);
  // R5: without compare enable the level only moves on overflow
  a_r5_no_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !ovf_i && !cmp_en_i && !start_i && !halt_i |=> $stable(lvl_q));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              pwm_o,
  output logic              run_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] load, match;
  logic             start, halt, ovf, cmp;

  pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ovf_i(ovf), .ctrl_o(ctrl), .load_o(load), .match_o(match),
    .start_o(start), .halt_o(halt)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .start_i(start), .run_i(ctrl.run),
    .auto_rld_i(ctrl.auto_rld), .load_i(load), .match_i(match),
    .ovf_o(ovf), .cmp_o(cmp)
  );

  pwm_wave u_wave (
    .clk_i, .rst_ni, .start_i(start), .halt_i(halt), .run_i(ctrl.run),
    .ovf_i(ovf), .cmp_i(cmp), .cmp_en_i(ctrl.cmp_en),
    .trig_both_i(ctrl.trig_both), .pol_i(ctrl.pol), .pwm_o(pwm_o)
  );

  assign run_o = ctrl.run;

  // R7: stopped pin rests at polarity idle
  a_r7_idle_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> pwm_o == ctrl.pol);
endmodule

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;
  localparam logic [31:0] MAX = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pwm, run;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  pwm_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .run_o(run)
  );

  // behavioural reference
  bit          m_run, m_ar, m_ce, m_pol, m_trig, m_lvl;
  logic [31:0] m_cnt, m_mact, m_load, m_match;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_ar = 0; m_ce = 0; m_pol = 0; m_trig = 0; m_lvl = 0;
      m_cnt = 0; m_mact = 0; m_load = 0; m_match = 0;
    end else begin
      bit wc, go, ovf, hit, nrun, stop;
      wc   = wr_en && wr_addr == 2'd0;
      go   = wc && wr_data[0] && !m_run;
      ovf  = m_run && m_cnt == MAX;
      hit  = m_run && m_cnt == m_mact;
      if (wc && !wr_data[0]) nrun = 0;
      else if (go) nrun = 1;
      else if (ovf && !m_ar) nrun = 0;
      else nrun = m_run;
      stop = m_run && !nrun;
      if (go || stop) m_lvl = 0;
      else if (ovf) m_lvl = m_trig ? 1'b0 : !m_lvl;
      else if (hit && m_ce && m_trig) m_lvl = !m_lvl;
      if (go) begin m_cnt = m_load + 1; m_mact = m_match; end
      else if (m_run) begin
        if (ovf) begin
          if (m_ar) begin m_cnt = m_load + 1; m_mact = m_match; end
        end else m_cnt = m_cnt + 1;
      end
      m_run = nrun;
      if (wc) begin
        m_ar = wr_data[1]; m_ce = wr_data[2]; m_pol = wr_data[3]; m_trig = wr_data[4];
      end
      if (wr_en && wr_addr == 2'd1) m_load = wr_data;
      if (wr_en && wr_addr == 2'd2) m_match = wr_data;
    end
  end

  always @(negedge clk) begin
    n_chk++;
    if (run !== m_run || pwm !== (m_lvl ^ m_pol)) begin
      n_fail++;
      $display("FAIL %s t=%0t run=%b pwm=%b expected run=%b pwm=%b",
               cur_req, $time, run, pwm, m_run, m_lvl ^ m_pol);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #100_000;
    n_fail++;
    $display("FAIL watchdog %s run=%b pwm=%b expected run end", cur_req, run, pwm);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R2: reset state explicit
    n_chk++;
    if (run !== 1'b0 || pwm !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 run=%b pwm=%b expected 0 0", run, pwm);
    end
    cur_req = "R1";
    wr(2'd3, 32'h0000_001F);
    idle(4);
    cur_req = "R3/R4";
    wr(2'd1, MAX - 32'd10);
    wr(2'd2, MAX - 32'd4);
    wr(2'd0, 32'h17);
    idle(35);
    cur_req = "R10";
    wr(2'd1, MAX - 32'd6);
    wr(2'd2, MAX - 32'd2);
    idle(30);
    cur_req = "R7/R11";
    wr(2'd0, 32'h1F);
    idle(20);
    cur_req = "R8";
    wr(2'd0, 32'h1D);
    idle(20);
    // R8: graceful stop must have ended the run at idle-high
    n_chk++;
    if (run !== 1'b0 || pwm !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 run=%b pwm=%b expected 0 1", run, pwm);
    end
    cur_req = "R5";
    wr(2'd0, 32'h13);
    idle(20);
    cur_req = "R9";
    wr(2'd0, 32'h00);
    idle(5);
    cur_req = "R6";
    wr(2'd0, 32'h03);
    idle(30);
    cur_req = "R8";
    wr(2'd0, 32'h01);
    idle(20);
    finish_run();
  end
endmodule